// File: doc/BRIEF.md
# Chainable Performance Counter Bank

A bank of 32-bit event counters and one 64-bit cycle counter, configured and read through a single-cycle write strobe and a combinational read port. Each event counter counts pulses on its own event input, or counts software-increment writes when its type register holds the software-increment code. A global run bit, per-counter enable bits, sticky overflow flags and interrupt enable bits combine into one level-sensitive overflow interrupt.

An odd-numbered counter whose type holds the chain code, and which is itself active, joins its even neighbour into one 64-bit counter. The even counter then holds the low word and carries into the odd counter, which holds the high word. Only the odd index raises an overflow flag. Forming or breaking a pair never changes either counter's value. A control-register field sets how many event counters are in use. Two control bits clear the cycle counter or all in-use event counters, and a long-mode bit moves the cycle counter's overflow point from bit 31 to bit 63.

Top module: `pcb_bank`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: The in-use field CTRL[15:11] (clamped to NUM_CNT) sets the valid mask: bits n-1..0 plus bit 31, or only bit 31 when it is 0. Counters outside the mask do not count and do not raise `irq`.
- R3: An event counter is active when CTRL[0] is set, its enable bit is set and its bit is in the valid mask. It then adds one for each cycle its `evt_in` bit is high and its type is neither 0x000 nor 0x01E. An unchained counter that wraps from 0xFFFFFFFF sets its own overflow bit.
- R4: When odd counter k has type 0x01E and is active, a wrap of counter k-1 adds one to counter k and does not set bit k-1. Counter k ignores its own `evt_in`, and a wrap of counter k sets overflow bit k.
- R5: Enabling or disabling the odd counter of a pair, and so forming or breaking the chain, leaves both counter values unchanged.
- R6: Writing a mask to SWINC (0x07) adds one to each masked counter that is active and has type 0x000. It does nothing while CTRL[0] is clear. Counters of type 0x000 ignore `evt_in`.
- R7: The cycle counter (bit 31 of the masks; halves at 0x08 and 0x09) adds one per clock while CTRL[0] and enable bit 31 are set. It sets overflow bit 31 when its low word wraps if CTRL[3] is clear, and only on a full 64-bit wrap if CTRL[3] is set.
- R8: A CTRL write with bit 2 set clears the cycle counter. A CTRL write with bit 1 set clears every event counter that the valid mask in force before the write selects.
- R9: `irq` is high exactly when CTRL[0] is set and some bit is set in overflow AND enable AND interrupt-enable AND valid mask.
- R10: Overflow bits are set by counter wraps or by writing ones to 0x03, and are cleared only by writing ones to 0x04. From the edge that captures the clear, `irq` reflects the cleared flags.
- R11: Type writes (0x40+i) keep only the event-number field: 10 bits when WIDE_EVT is 0, 16 bits otherwise.
- R12: Enable (0x01 set, 0x02 clear) and interrupt-enable (0x05 set, 0x06 clear) are write-one-to-set and write-one-to-clear. Both addresses of a pair read the current mask, and only implemented bits can be set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 7 | Write register address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 7 | Read register address |
| rd_data | output | 32 | Combinational read data |
| evt_in | input | NUM_CNT | One event pulse per counter per cycle |
| irq | output | 1 | Level-sensitive overflow interrupt |

## Verification
A wrong chain state shows up on the first low-word wrap. The high counter either misses its carry, or counts its own events, or the wrong overflow bit rises. Each of these is visible one cycle later on `rd_data` and, with interrupts enabled, on `irq`. A stale enable, valid mask or overflow flag shows up on `irq` in the cycle after the state changes. The bench model tracks every counter each cycle, so a single missed or extra count is reported at the next clock edge.

// File: rtl/pcb_pkg.sv
// Shared constants for the chainable performance counter bank.
// Assumes a 7-bit register address space and 32-bit register data.
package pcb_pkg;
    localparam int ADDR_W  = 7;
    localparam int CYC_IDX = 31;

    localparam logic [6:0] A_CTRL    = 7'h00;
    localparam logic [6:0] A_EN_SET  = 7'h01;
    localparam logic [6:0] A_EN_CLR  = 7'h02;
    localparam logic [6:0] A_OVF_SET = 7'h03;
    localparam logic [6:0] A_OVF_CLR = 7'h04;
    localparam logic [6:0] A_IEN_SET = 7'h05;
    localparam logic [6:0] A_IEN_CLR = 7'h06;
    localparam logic [6:0] A_SWINC   = 7'h07;
    localparam logic [6:0] A_CYC_LO  = 7'h08;
    localparam logic [6:0] A_CYC_HI  = 7'h09;
    localparam logic [6:0] A_CNT_BASE = 7'h20;
    localparam logic [6:0] A_TYP_BASE = 7'h40;

    localparam int CB_RUN  = 0;
    localparam int CB_PRST = 1;
    localparam int CB_CRST = 2;
    localparam int CB_LONG = 3;
    localparam int N_LSB   = 11;
    localparam int N_W     = 5;

    localparam logic [15:0] EV_SWINC = 16'h0000;
    localparam logic [15:0] EV_CHAIN = 16'h001E;

    // Event-number field mask for the selected field width.
    function automatic logic [15:0] evt_mask(input bit wide);
        return wide ? 16'hFFFF : 16'h03FF;
    endfunction

    // Bits that exist in the bank: the event counters plus the cycle bit.
    function automatic logic [31:0] impl_mask(input int ncnt);
        logic [31:0] m;
        m = (32'd1 << ncnt) - 32'd1;
        m[CYC_IDX] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/pcb_evt_ctr.sv
// One event counter: load, clear and increment, with a wrap flag.
// Assumes load has priority over clear, and clear over increment.
// The wrap flag is combinational and marks an increment taken from all ones.
module pcb_evt_ctr #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic [CW-1:0] ld_val,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] val,
    output logic          wrap
);
    // Counter register update.
    always_ff @(posedge clk) begin
        if (!rst_n)   val <= '0;
        else if (ld)  val <= ld_val;
        else if (clr) val <= '0;
        else if (inc) val <= val + 1'b1;
    end

    // Flag an increment that rolls the register over to zero.
    assign wrap = inc && !ld && !clr && (&val);
endmodule

// File: rtl/pcb_cyc_ctr.sv
// 64-bit cycle counter with half-word loads and a selectable overflow point.
// Assumes at most one half is loaded per cycle; counting pauses on that cycle.
module pcb_cyc_ctr #(
    parameter int HW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_lo,
    input  logic          ld_hi,
    input  logic [HW-1:0] ld_val,
    input  logic          clr,
    input  logic          inc,
    input  logic          long_mode,
    output logic [2*HW-1:0] val,
    output logic          ovf
);
    // Counter register update.
    always_ff @(posedge clk) begin
        if (!rst_n)     val <= '0;
        else if (ld_lo) val <= {val[2*HW-1:HW], ld_val};
        else if (ld_hi) val <= {ld_val, val[HW-1:0]};
        else if (clr)   val <= '0;
        else if (inc)   val <= val + 1'b1;
    end

    // Overflow at the top of the low word, or of the full word in long mode.
    always_comb begin
        ovf = inc && !ld_lo && !ld_hi && !clr &&
              (long_mode ? (&val) : (&val[HW-1:0]));
    end
endmodule

// File: rtl/pcb_pair_link.sv
// Chain decision for one even/odd counter pair.
// Assumes the odd counter's own increment request is already zero for the
// chain type. When chained, the odd counter takes the even counter's carry.
module pcb_pair_link
    import pcb_pkg::*;
(
    input  logic [15:0] odd_type,
    input  logic        odd_active,
    input  logic        low_wrap,
    input  logic        own_inc,
    output logic        chained,
    output logic        inc
);
    // Pair is joined only while the odd counter is active with the chain code.
    assign chained = odd_active && (odd_type == EV_CHAIN);
    // Select carry or own event as the odd counter's increment.
    assign inc     = chained ? low_wrap : own_inc;
endmodule

// File: rtl/pcb_bank.sv
// Chainable performance counter bank: NUM_CNT 32-bit event counters, a 64-bit
// cycle counter, enable / overflow / interrupt-enable masks and one
// level-sensitive overflow interrupt. Assumes 2 <= NUM_CNT <= 30, at most one
// register write per cycle, and a combinational read port.
module pcb_bank
    import pcb_pkg::*;
#(
    parameter int NUM_CNT  = 6,
    parameter bit WIDE_EVT = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [31:0]        wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [31:0]        rd_data,
    input  logic [NUM_CNT-1:0] evt_in,
    output logic               irq
);
    localparam int          NPAIR = NUM_CNT / 2;
    localparam logic [31:0] IMPL  = impl_mask(NUM_CNT);
    localparam logic [15:0] EVM   = evt_mask(WIDE_EVT);
    localparam logic [N_W-1:0] NMAX = N_W'(NUM_CNT);

    logic                run_q, long_q;
    logic [N_W-1:0]      nfld_q, n_eff;
    logic [31:0]         en_q, ovf_q, ien_q, valid;
    logic [NUM_CNT-1:0][15:0] typ_q;
    logic [NUM_CNT-1:0][31:0] cnt_val;
    logic [NUM_CNT-1:0]  active, own_inc, inc, wrap, hit, ld, clr;
    logic [NPAIR-1:0]    chained;
    logic [63:0]         cyc_val;
    logic                cyc_ovf, cyc_inc;
    logic [31:0]         hit_vec;

    logic wr_ctrl, wr_enset, wr_enclr, wr_ovfset, wr_ovfclr;
    logic wr_ienset, wr_ienclr, wr_swinc, wr_cyclo, wr_cychi, p_clr, c_clr;

    // Register address decode.
    always_comb begin
        wr_ctrl   = wr_en && (wr_addr == A_CTRL);
        wr_enset  = wr_en && (wr_addr == A_EN_SET);
        wr_enclr  = wr_en && (wr_addr == A_EN_CLR);
        wr_ovfset = wr_en && (wr_addr == A_OVF_SET);
        wr_ovfclr = wr_en && (wr_addr == A_OVF_CLR);
        wr_ienset = wr_en && (wr_addr == A_IEN_SET);
        wr_ienclr = wr_en && (wr_addr == A_IEN_CLR);
        wr_swinc  = wr_en && (wr_addr == A_SWINC);
        wr_cyclo  = wr_en && (wr_addr == A_CYC_LO);
        wr_cychi  = wr_en && (wr_addr == A_CYC_HI);
        p_clr     = wr_ctrl && wr_data[CB_PRST];
        c_clr     = wr_ctrl && wr_data[CB_CRST];
    end

    // Valid-counter mask from the in-use field, clamped to the bank size.
    always_comb begin
        n_eff = (nfld_q > NMAX) ? NMAX : nfld_q;
        valid = (32'd1 << n_eff) - 32'd1;
        valid[CYC_IDX] = 1'b1;
    end

    // Control, enable and interrupt-enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            long_q <= 1'b0;
            nfld_q <= '0;
            en_q   <= '0;
            ien_q  <= '0;
        end else begin
            if (wr_ctrl) begin
                run_q  <= wr_data[CB_RUN];
                long_q <= wr_data[CB_LONG];
                nfld_q <= wr_data[N_LSB +: N_W];
            end
            if (wr_enset)  en_q  <= en_q  | (wr_data & IMPL);
            if (wr_enclr)  en_q  <= en_q  & ~wr_data;
            if (wr_ienset) ien_q <= ien_q | (wr_data & IMPL);
            if (wr_ienclr) ien_q <= ien_q & ~wr_data;
        end
    end

    // Collect overflow events from all counters into one mask.
    always_comb begin
        hit_vec = '0;
        hit_vec[NUM_CNT-1:0] = hit;
        hit_vec[CYC_IDX] = cyc_ovf;
    end

    // Sticky overflow flags: new events win over a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) ovf_q <= '0;
        else ovf_q <= (ovf_q & ~(wr_ovfclr ? wr_data : 32'd0))
                    | (wr_ovfset ? (wr_data & IMPL) : 32'd0)
                    | hit_vec;
    end

    // Per-counter type register, counter and pair wiring.
    for (genvar i = 0; i < NUM_CNT; i++) begin : g_ctr
        localparam logic [6:0] CA = 7'(A_CNT_BASE + i);
        localparam logic [6:0] TA = 7'(A_TYP_BASE + i);

        // Type register, written with the event field mask applied.
        always_ff @(posedge clk) begin
            if (!rst_n) typ_q[i] <= '0;
            else if (wr_en && (wr_addr == TA)) typ_q[i] <= wr_data[15:0] & EVM;
        end

        assign ld[i]     = wr_en && (wr_addr == CA);
        assign clr[i]    = p_clr && valid[i];
        assign active[i] = run_q && en_q[i] && valid[i];
        assign own_inc[i] = active[i] && (typ_q[i] != EV_CHAIN) &&
                            ((typ_q[i] == EV_SWINC) ? (wr_swinc && wr_data[i])
                                                    : evt_in[i]);

        if (i % 2 == 1) begin : g_hi
            pcb_pair_link u_link (
                .odd_type  (typ_q[i]),
                .odd_active(active[i]),
                .low_wrap  (wrap[i-1]),
                .own_inc   (own_inc[i]),
                .chained   (chained[i/2]),
                .inc       (inc[i])
            );
            assign hit[i] = wrap[i];
        end else if (i + 1 < NUM_CNT) begin : g_lo
            assign inc[i] = own_inc[i];
            assign hit[i] = wrap[i] && !chained[i/2];
        end else begin : g_solo
            assign inc[i] = own_inc[i];
            assign hit[i] = wrap[i];
        end

        pcb_evt_ctr #(.CW(32)) u_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .ld    (ld[i]),
            .ld_val(wr_data),
            .clr   (clr[i]),
            .inc   (inc[i]),
            .val   (cnt_val[i]),
            .wrap  (wrap[i])
        );
    end

    assign cyc_inc = run_q && en_q[CYC_IDX];

    pcb_cyc_ctr #(.HW(32)) u_cyc (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_lo    (wr_cyclo),
        .ld_hi    (wr_cychi),
        .ld_val   (wr_data),
        .clr      (c_clr),
        .inc      (cyc_inc),
        .long_mode(long_q),
        .val      (cyc_val),
        .ovf      (cyc_ovf)
    );

    // Level interrupt from enabled, valid, flagged counters while running.
    assign irq = run_q && (|(ovf_q & en_q & ien_q & valid));

    // Combinational register read.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CTRL: begin
                rd_data[CB_RUN]         = run_q;
                rd_data[CB_LONG]        = long_q;
                rd_data[N_LSB +: N_W]   = nfld_q;
            end
            A_EN_SET, A_EN_CLR:   rd_data = en_q;
            A_OVF_SET, A_OVF_CLR: rd_data = ovf_q;
            A_IEN_SET, A_IEN_CLR: rd_data = ien_q;
            A_CYC_LO:             rd_data = cyc_val[31:0];
            A_CYC_HI:             rd_data = cyc_val[63:32];
            default: begin
                for (int i = 0; i < NUM_CNT; i++) begin
                    if (rd_addr == 7'(A_CNT_BASE + i)) rd_data = cnt_val[i];
                    if (rd_addr == 7'(A_TYP_BASE + i)) rd_data = {16'd0, typ_q[i]};
                end
            end
        endcase
    end
endmodule

// File: rtl/pcb_bank_chk.sv
// Property checker for pcb_bank, attached by bind. Observes the write port,
// the interrupt and the control/mask/cycle state of the bank.
module pcb_bank_chk
    import pcb_pkg::*;
#(
    parameter int NUM_CNT = 6
) (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [6:0]  wr_addr,
    input logic [31:0] wr_data,
    input logic        irq,
    input logic        run,
    input logic [31:0] en,
    input logic [31:0] ovf,
    input logic [31:0] ien,
    input logic [63:0] cyc
);
    localparam logic [31:0] IMPL = impl_mask(NUM_CNT);

    // Overflow flags never drop without a clear write (R10).
    assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == A_OVF_CLR) |=> ((ovf & $past(ovf)) == $past(ovf)));

    // With counting stopped, a clear write removes the written flags (R10).
    assert_ovf_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_OVF_CLR && !run) |=> ((ovf & $past(wr_data)) == 32'd0));

    // The interrupt needs run and one enabled, flagged counter (R9).
    assert_irq_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (run && ((ovf & en & ien) != 32'd0)));

    // The running cycle counter advances by one when nothing is written (R7).
    assert_cyc_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && en[CYC_IDX] && !wr_en) |=> (cyc == $past(cyc) + 64'd1));

    // With run clear and no writes the cycle counter holds (R7).
    assert_cyc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_en) |=> $stable(cyc));

    // An enable-set write sets every implemented written bit (R12).
    assert_en_set_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_EN_SET) |=>
        ((en & $past(wr_data & IMPL)) == $past(wr_data & IMPL)));
endmodule

bind pcb_bank pcb_bank_chk #(.NUM_CNT(NUM_CNT)) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .irq    (irq),
    .run    (run_q),
    .en     (en_q),
    .ovf    (ovf_q),
    .ien    (ien_q),
    .cyc    (cyc_val)
);

// File: tb/pcb_bank_tb_top.sv
// Bench for pcb_bank: a behavioural model stepped on every clock and compared
// every cycle, plus directed checks named by requirement.
module pcb_bank_tb_top;
    localparam int NC = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [6:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [6:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [NC-1:0] evt_in = '0;
    logic        irq;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pcb_bank #(.NUM_CNT(NC), .WIDE_EVT(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .evt_in(evt_in), .irq(irq)
    );

    // ---------------- reference model ----------------
    bit        m_run, m_long;
    bit [4:0]  m_n;
    bit [31:0] m_en, m_ovf, m_ien;
    bit [31:0] m_cnt [NC];
    bit [15:0] m_typ [NC];
    bit [63:0] m_cyc;

    function automatic bit [31:0] m_valid();
        int k = (m_n > NC) ? NC : int'(m_n);
        bit [31:0] v = 32'h8000_0000;
        for (int j = 0; j < k; j++) v[j] = 1'b1;
        return v;
    endfunction

    function automatic bit m_irq();
        return m_run && ((m_ovf & m_en & m_ien & m_valid()) != 0);
    endfunction

    function automatic bit [31:0] m_read(input bit [6:0] a);
        if (a == 7'h00) return {16'd0, m_n, 7'd0, m_long, 2'd0, m_run};
        if (a == 7'h01 || a == 7'h02) return m_en;
        if (a == 7'h03 || a == 7'h04) return m_ovf;
        if (a == 7'h05 || a == 7'h06) return m_ien;
        if (a == 7'h08) return m_cyc[31:0];
        if (a == 7'h09) return m_cyc[63:32];
        for (int j = 0; j < NC; j++) begin
            if (a == 7'(32 + j)) return m_cnt[j];
            if (a == 7'(64 + j)) return {16'd0, m_typ[j]};
        end
        return 32'd0;
    endfunction

    // Step the model by one clock from the values seen at the edge.
    always @(posedge clk) begin : model_step
        bit [31:0] vm, act, impl;
        bit carry [NC];
        bit [31:0] hits;
        bit [31:0] nxt [NC];
        bit [63:0] ncyc;
        if (!rst_n) begin
            m_run = 0; m_long = 0; m_n = 0; m_en = 0; m_ovf = 0; m_ien = 0;
            m_cyc = 0;
            for (int j = 0; j < NC; j++) begin m_cnt[j] = 0; m_typ[j] = 0; end
        end else begin
            vm = m_valid();
            impl = 32'h8000_0000 | ((32'd1 << NC) - 1);
            hits = 0;
            for (int j = 0; j < NC; j++) act[j] = m_run && m_en[j] && vm[j];
            for (int j = 0; j < NC; j++) begin
                bit incr, is_hi_chain, is_lo_chain, ldj, clrj;
                is_hi_chain = (j % 2 == 1) && act[j] && m_typ[j] == 16'h001E;
                is_lo_chain = (j % 2 == 0) && (j + 1 < NC) && act[j+1] && m_typ[j+1] == 16'h001E;
                if (is_hi_chain) incr = carry[j-1];
                else if (!act[j] || m_typ[j] == 16'h001E) incr = 0;
                else if (m_typ[j] == 16'h0000) incr = wr_en && wr_addr == 7'h07 && wr_data[j];
                else incr = evt_in[j];
                ldj  = wr_en && wr_addr == 7'(32 + j);
                clrj = wr_en && wr_addr == 7'h00 && wr_data[1] && vm[j];
                carry[j] = 0;
                if (ldj) nxt[j] = wr_data;
                else if (clrj) nxt[j] = 0;
                else if (incr) begin
                    if (m_cnt[j] == 32'hFFFF_FFFF) begin
                        nxt[j] = 0; carry[j] = 1;
                        if (!is_lo_chain) hits[j] = 1;
                    end else nxt[j] = m_cnt[j] + 1;
                end else nxt[j] = m_cnt[j];
            end
            ncyc = m_cyc;
            if (wr_en && wr_addr == 7'h08) ncyc[31:0] = wr_data;
            else if (wr_en && wr_addr == 7'h09) ncyc[63:32] = wr_data;
            else if (wr_en && wr_addr == 7'h00 && wr_data[2]) ncyc = 0;
            else if (m_run && m_en[31]) begin
                if (m_long ? (m_cyc == 64'hFFFF_FFFF_FFFF_FFFF) : (m_cyc[31:0] == 32'hFFFF_FFFF))
                    hits[31] = 1;
                ncyc = m_cyc + 1;
            end
            m_cyc = ncyc;
            for (int j = 0; j < NC; j++) m_cnt[j] = nxt[j];
            if (wr_en && wr_addr == 7'h04) m_ovf = m_ovf & ~wr_data;
            if (wr_en && wr_addr == 7'h03) m_ovf = m_ovf | (wr_data & impl);
            m_ovf = m_ovf | hits;
            if (wr_en) begin
                case (wr_addr)
                    7'h00: begin m_run = wr_data[0]; m_long = wr_data[3]; m_n = wr_data[15:11]; end
                    7'h01: m_en  = m_en  | (wr_data & impl);
                    7'h02: m_en  = m_en  & ~wr_data;
                    7'h05: m_ien = m_ien | (wr_data & impl);
                    7'h06: m_ien = m_ien & ~wr_data;
                    default: ;
                endcase
                for (int j = 0; j < NC; j++)
                    if (wr_addr == 7'(64 + j)) m_typ[j] = wr_data[15:0] & 16'h03FF;
            end
        end
    end

    // ---------------- checking ----------------
    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    // Compare the design with the model after every edge (R3 R4 R6 R7 R9).
    always @(posedge clk) begin
        #2;
        if (rst_n && !done) begin
            chk("R9 per-cycle irq", {63'd0, irq}, {63'd0, m_irq()});
            chk("R3 per-cycle read", {32'd0, rd_data}, {32'd0, m_read(rd_addr)});
        end
    end

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input logic [NC-1:0] m);
        @(negedge clk);
        evt_in = m;
        @(negedge clk);
        evt_in = '0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(5ns * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        idle(3);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(7'h00, v); chk("R1 ctrl", v, 0);
        rd(7'h01, v); chk("R1 enable", v, 0);
        rd(7'h20, v); chk("R1 counter0", v, 0);
        chk("R1 irq", irq, 0);

        // R3: basic event counting
        wr(7'h00, 32'h0000_3001);            // run, six counters in use
        wr(7'h40, 32'h0000_0011);
        wr(7'h01, 32'h0000_000F);
        pulse(6'b000001); pulse(6'b000001); pulse(6'b000001);
        rd(7'h20, v); chk("R3 three events", v, 3);

        // R3: wrap sets own overflow
        wr(7'h20, 32'hFFFF_FFFE);
        pulse(6'b000001); pulse(6'b000001);
        rd(7'h20, v); chk("R3 wrapped value", v, 0);
        rd(7'h03, v); chk("R3 overflow bit0", v & 1, 1);

        // R9: interrupt gating
        chk("R9 irq off without enable", irq, 0);
        wr(7'h05, 32'h0000_0001);
        chk("R9 irq on", irq, 1);
        wr(7'h00, 32'h0000_3000);
        chk("R9 irq low when stopped", irq, 0);
        wr(7'h00, 32'h0000_3001);
        chk("R9 irq back", irq, 1);

        // R10: clear overflow
        wr(7'h04, 32'h0000_0001);
        chk("R10 irq after clear", irq, 0);
        rd(7'h03, v); chk("R10 flag cleared", v & 1, 0);
        wr(7'h03, 32'h0000_0004);
        rd(7'h03, v); chk("R10 flag set by write", v & 4, 4);
        wr(7'h04, 32'h0000_0004);

        // R11: type field masked to 10 bits
        wr(7'h43, 32'h0000_FC1E);
        rd(7'h43, v); chk("R11 type mask", v, 32'h1E);

        // R4: chained pair 2/3
        wr(7'h42, 32'h0000_0011);
        wr(7'h22, 32'hFFFF_FFFF);
        wr(7'h23, 32'h0000_0005);
        pulse(6'b001100);
        rd(7'h22, v); chk("R4 low word wrapped", v, 0);
        rd(7'h23, v); chk("R4 high word carry only", v, 6);
        rd(7'h03, v); chk("R4 no low overflow", v & 4, 0);

        // R5: breaking and forming keep values
        wr(7'h02, 32'h0000_0008);
        rd(7'h22, v); chk("R5 low kept on break", v, 0);
        rd(7'h23, v); chk("R5 high kept on break", v, 6);
        pulse(6'b000100);
        rd(7'h22, v); chk("R5 low counts alone", v, 1);
        wr(7'h01, 32'h0000_0008);
        rd(7'h23, v); chk("R5 high kept on form", v, 6);

        // R6: software increment
        wr(7'h21, 32'hFFFF_FFFF);
        wr(7'h07, 32'h0000_0002);
        rd(7'h21, v); chk("R6 swinc wrap", v, 0);
        rd(7'h03, v); chk("R6 swinc overflow bit1", v & 2, 2);
        pulse(6'b000010);
        rd(7'h21, v); chk("R6 events ignored by swinc type", v, 0);
        wr(7'h07, 32'h0000_0001);
        rd(7'h20, v); chk("R6 swinc ignored on other type", v, 0);
        wr(7'h00, 32'h0000_3000);
        wr(7'h07, 32'h0000_0002);
        rd(7'h21, v); chk("R6 swinc ignored when stopped", v, 0);
        wr(7'h00, 32'h0000_3001);

        // R4: chained software increment on pair 4/5
        wr(7'h45, 32'h0000_001E);
        wr(7'h01, 32'h0000_0030);
        wr(7'h24, 32'hFFFF_FFFF);
        wr(7'h25, 32'hFFFF_FFFF);
        wr(7'h07, 32'h0000_0010);
        rd(7'h24, v); chk("R4 swinc low", v, 0);
        rd(7'h25, v); chk("R4 swinc high", v, 0);
        rd(7'h03, v); chk("R4 overflow only on high", v & 32'h30, 32'h20);

        // R2: in-use field shrinks the valid mask
        wr(7'h00, 32'h0000_1001);
        pulse(6'b000001);
        rd(7'h20, v); chk("R2 counter0 in range", v, 1);
        pulse(6'b000100);
        rd(7'h22, v); chk("R2 counter2 out of range", v, 1);
        wr(7'h05, 32'h0000_0020);
        chk("R2 irq ignores invalid", irq, 0);
        wr(7'h00, 32'h0000_3001);
        chk("R2 irq when valid again", irq, 1);
        wr(7'h04, 32'hFFFF_FFFF);
        chk("R10 full clear", irq, 0);

        // R8: event counter reset
        wr(7'h00, 32'h0000_3003);
        rd(7'h23, v); chk("R8 counter3 cleared", v, 0);
        rd(7'h20, v); chk("R8 counter0 cleared", v, 0);

        // R7: cycle counter, 32-bit overflow point
        wr(7'h08, 32'hFFFF_FFF0);
        wr(7'h01, 32'h8000_0000);
        idle(40);
        rd(7'h03, v); chk("R7 short overflow", v[31], 1);
        rd(7'h09, v); chk("R7 carries into high word", v, 1);

        // R7: long mode, no overflow at the low-word wrap
        wr(7'h00, 32'h0000_3009);
        wr(7'h04, 32'h8000_0000);
        wr(7'h09, 32'hFFFF_FFFE);
        wr(7'h08, 32'hFFFF_FFF0);
        idle(40);
        rd(7'h03, v); chk("R7 long no low overflow", v[31], 0);
        wr(7'h09, 32'hFFFF_FFFF);
        wr(7'h08, 32'hFFFF_FFF0);
        idle(40);
        rd(7'h03, v); chk("R7 long overflow", v[31], 1);

        // R8: cycle counter reset
        wr(7'h00, 32'h0000_300D);
        rd(7'h09, v); chk("R8 cycle high cleared", v, 0);

        // R12: mask set/clear
        wr(7'h06, 32'hFFFF_FFFF);
        rd(7'h05, v); chk("R12 ien cleared", v, 0);
        wr(7'h01, 32'hFFFF_FFFF);
        rd(7'h02, v); chk("R12 only implemented enables", v, 32'h8000_003F);

        idle(2);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule